// File: doc/BRIEF.md
# Keyed Windowed Watchdog with Clock Monitor

This block is a watchdog timer that counts instruction-cycle ticks. Software keeps it quiet by writing an 8-bit service word. Each word carries three fields: a window select, a fixed 5-bit key and a clock-monitor enable. A service is accepted only when three conditions hold. The key must be right. The write must land inside a window that has both a lower and an upper edge. The clock monitor must not be reporting a fault. Any failed service, any missed window and any new clock-monitor fault produces a one-cycle error pulse. After an error the window starts again.

The window select and the monitor enable can be set once, by the first service after reset. That first service is checked against the key only, and it may come at any point in the initial window. Every later service must repeat the stored fields exactly. The counter freezes in HALT and in IDLE. The clock monitor stays awake in both modes, so entering HALT with the monitor enabled is reported. Leaving IDLE acts as a service performed by hardware.

Top module: `wdg_keyed_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `err_o` is 0 and `rdata_o` reads 8'hC1. That value means window select 2'b11, the longest window, and clock monitor enabled.
- R2: The service word layout is: bits [7:6] window select, bits [5:1] key, bit [0] monitor enable. The key is 5'b01100. `rdata_o` returns the stored select and enable, with bits [5:1] always 0.
- R3: The first write after reset is checked against the key only, and it is accepted even with 0 ticks elapsed. A correct key loads the select and enable fields. A wrong key gives an error and loads nothing. Either way, the write uses up the one-time configuration.
- R4: After the first write, writes never change `rdata_o`. A later write whose select or enable field differs from the stored value gives an error.
- R5: Let MIN = 2^LO_LOG2. A write after the first one that comes fewer than MIN ticks after the last window restart gives an error. The same write at exactly MIN ticks does not.
- R6: Let LIM = 2^(LO_LOG2+sel+2). If LIM ticks pass without a service, `err_o` pulses in the cycle after the LIM-th tick. A valid service after LIM-1 ticks gives no error.
- R7: Every error is a single-cycle pulse that appears in the cycle after its cause. Any service attempt, and any error, restarts the window from 0.
- R8: While `halt_i` or `idle_i` is high, ticks are not counted and writes are ignored. An ignored write causes no error, no restart and no configuration change.
- R9: With the monitor enabled, a rising edge of (`clk_fail_i` or `halt_i`) gives one error pulse. A write made while that condition holds gives an error. With the monitor disabled, neither input causes an error.
- R10: A pulse on `idle_exit_i` restarts the window, so the lower bound applies to the next software service.
- R11: While `rst_ni` is low, `err_o` stays 0 whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One pulse per instruction cycle |
| wr_i | input | 1 | Service-word write strobe |
| wdata_i | input | 8 | Service word |
| halt_i | input | 1 | HALT mode flag |
| idle_i | input | 1 | IDLE mode flag |
| idle_exit_i | input | 1 | One-cycle pulse when IDLE ends |
| clk_fail_i | input | 1 | Clock-failure indication |
| err_o | output | 1 | One-cycle watchdog error pulse |
| rdata_o | output | 8 | Service register read-back |

## Verification
The bench walks the service time from 0 to MIN+1 ticks, one step at a time. An off-by-one in the lower edge shows up as an error pulse at exactly MIN, or as a missing pulse at MIN-1. The timeout is probed at LIM-1 and LIM ticks, both for the reset window and for the smallest window. A wrong limit or wrong counter width moves the pulse, or makes it vanish. Further tests cover a first write with a bad key, writes made during IDLE, HALT with the monitor both off and on, and an IDLE exit part-way through a window. A design that reconfigured on a later write, counted while suspended, or kept its count across a hardware service would produce an error pulse in the wrong cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int          SEL_W   = 2;
    localparam int          KEY_W   = 5;
    localparam logic [KEY_W-1:0] WDG_KEY = 5'b01100;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [KEY_W-1:0] key;
        logic             cm_en;
    } svc_word_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             cm_en;
        logic             locked;
        logic             err;
    } ctl_t;
endpackage

// File: rtl/wdg_window.sv
module wdg_window #(
    parameter int LO_LOG2 = 11,
    parameter int SEL_W   = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             early_o,
    output logic             expire_o
);
    localparam int NSEL = 1 << SEL_W;
    localparam int CW   = LO_LOG2 + NSEL + 1;

    logic [CW-1:0] lim_m1 [NSEL];
    logic [CW-1:0] cnt_d, cnt_q;

    // Last count value of each window: 2^(LO_LOG2+sel+2) - 1
    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_lim
            assign lim_m1[g] = CW'((64'd1 << (LO_LOG2 + g + 2)) - 64'd1);
        end
    endgenerate

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (tick_i && run_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign early_o  = (cnt_q[CW-1:LO_LOG2] == '0);
    assign expire_o = tick_i && run_i && (cnt_q == lim_m1[sel_i]);
endmodule

// File: rtl/wdg_clkmon.sv
module wdg_clkmon (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cm_en_i,
    input  logic clk_fail_i,
    input  logic halt_i,
    output logic fault_o,
    output logic rise_o
);
    logic fault_d, fault_q;

    always_comb begin
        fault_d = cm_en_i && (clk_fail_i || halt_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fault_q <= 1'b0;
        else         fault_q <= fault_d;
    end

    assign fault_o = fault_d;
    assign rise_o  = fault_d && !fault_q;
endmodule

// File: rtl/wdg_svc_check.sv
module wdg_svc_check
    import wdg_pkg::*;
(
    input  svc_word_t        word_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             cm_en_i,
    input  logic             locked_i,
    input  logic             early_i,
    input  logic             fault_i,
    output logic             key_ok_o,
    output logic             ok_o
);
    logic fields_ok;

    always_comb begin
        key_ok_o  = (word_i.key == WDG_KEY);
        fields_ok = (word_i.sel == sel_i) && (word_i.cm_en == cm_en_i);
        if (!locked_i) ok_o = key_ok_o && !fault_i;
        else           ok_o = key_ok_o && !fault_i && fields_ok && !early_i;
    end
endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
    import wdg_pkg::*;
#(
    parameter int LO_LOG2 = 11
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    input  logic       halt_i,
    input  logic       idle_i,
    input  logic       idle_exit_i,
    input  logic       clk_fail_i,
    output logic       err_o,
    output logic [7:0] rdata_o
);
    ctl_t      d, q;
    svc_word_t word;
    logic run, svc, early, expire, fault, rise, key_ok, ok, restart;

    assign word    = svc_word_t'(wdata_i);
    assign run     = !halt_i && !idle_i;
    assign svc     = wr_i && run;
    assign restart = svc || expire || rise || idle_exit_i;

    wdg_window #(.LO_LOG2(LO_LOG2), .SEL_W(SEL_W)) u_window (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .run_i     (run),
        .restart_i (restart),
        .sel_i     (q.sel),
        .early_o   (early),
        .expire_o  (expire)
    );

    wdg_clkmon u_clkmon (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cm_en_i    (q.cm_en),
        .clk_fail_i (clk_fail_i),
        .halt_i     (halt_i),
        .fault_o    (fault),
        .rise_o     (rise)
    );

    wdg_svc_check u_check (
        .word_i   (word),
        .sel_i    (q.sel),
        .cm_en_i  (q.cm_en),
        .locked_i (q.locked),
        .early_i  (early),
        .fault_i  (fault),
        .key_ok_o (key_ok),
        .ok_o     (ok)
    );

    always_comb begin
        d     = q;
        d.err = (svc && !ok) || (!svc && expire) || rise;
        if (svc && !q.locked) begin
            d.locked = 1'b1;
            if (key_ok) begin
                d.sel   = word.sel;
                d.cm_en = word.cm_en;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.sel    <= '1;
            q.cm_en  <= 1'b1;
            q.locked <= 1'b0;
            q.err    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign err_o   = q.err;
    assign rdata_o = {q.sel, {KEY_W{1'b0}}, q.cm_en};
endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk
    import wdg_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wr_i,
    input logic [7:0] wdata_i,
    input logic       halt_i,
    input logic       idle_i,
    input logic       clk_fail_i,
    input logic       err_o,
    input logic [7:0] rdata_o
);
    logic seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          seen_q <= 1'b0;
        else if (wr_i && !halt_i && !idle_i)  seen_q <= 1'b1;
    end

    AST_NO_ERR_IN_RESET: assert property (@(posedge clk_i)
        !rst_ni |-> !err_o); // R11

    AST_BAD_KEY_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !halt_i && !idle_i && (wdata_i[5:1] != WDG_KEY)) |=> err_o); // R3

    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen_q |=> $stable(rdata_o)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idle_i && !halt_i && !clk_fail_i) |=> !err_o); // R8

    AST_HALT_MON_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_i && !rdata_o[0]) |=> !err_o); // R9
endmodule

bind wdg_keyed_top wdg_keyed_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .halt_i     (halt_i),
    .idle_i     (idle_i),
    .clk_fail_i (clk_fail_i),
    .err_o      (err_o),
    .rdata_o    (rdata_o)
);

// File: tb/wdg_keyed_top_tb.sv
module wdg_keyed_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LO_LOG2    = 3;
    localparam int MIN        = 1 << LO_LOG2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, wr = 1'b0, halt = 1'b0, idle = 1'b0;
    logic       idle_exit = 1'b0, clk_fail = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       err;
    logic [7:0] rdata;
    int         nchk = 0, nfail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdg_keyed_top #(.LO_LOG2(LO_LOG2)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .wdata_i(wdata),
        .halt_i(halt), .idle_i(idle), .idle_exit_i(idle_exit),
        .clk_fail_i(clk_fail), .err_o(err), .rdata_o(rdata)
    );

    function automatic int lim(int sel);
        return 1 << (LO_LOG2 + sel + 2);
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // n ticked cycles; no error may appear in any of them
    task automatic tick_n(int n, string tag);
        logic any = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            any |= err;
        end
        tick = 1'b0;
        chk(tag, {7'd0, any}, 8'h00);
    endtask

    // one more tick that must expire the window
    task automatic tick_expire(string tag);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk(tag, {7'd0, err}, 8'h01);
        @(negedge clk);
        chk({tag, " R7 pulse width"}, {7'd0, err}, 8'h00);
    endtask

    task automatic svc(logic [7:0] d, logic exp_err, string tag);
        wr = 1'b1;
        wdata = d;
        @(negedge clk);
        wr = 1'b0;
        chk(tag, {7'd0, err}, {7'd0, exp_err});
        if (exp_err) begin
            @(negedge clk);
            chk({tag, " R7 pulse width"}, {7'd0, err}, 8'h00);
        end
    endtask

    initial begin
        // R11: reset holds the error low under hostile inputs
        wr = 1'b1; wdata = 8'h00; clk_fail = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R11 err in reset", {7'd0, err}, 8'h00);
        end
        chk("R1 rdata in reset", rdata, 8'hC1);
        wr = 1'b0; clk_fail = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 err after reset", {7'd0, err}, 8'h00);
        chk("R1 R2 rdata after reset", rdata, 8'hC1);

        // R3: first service at 0 ticks, key only; sel=0, monitor off
        svc(8'h18, 1'b0, "R3 first service early");
        chk("R2 key reads zero", rdata, 8'h00);

        // R6: smallest window, boundary
        tick_n(lim(0) - 1, "R6 no error before limit");
        tick_expire("R6 timeout sel0");

        // R5: lower bound sweep
        for (int n = 0; n <= MIN + 1; n++) begin
            tick_n(n, "R5 quiet ticks");
            svc(8'h18, (n < MIN), $sformatf("R5 service after %0d ticks", n));
        end

        // R4: locked fields, wrong key
        tick_n(MIN, "R4 quiet");
        svc(8'h58, 1'b1, "R4 select mismatch");
        chk("R4 rdata unchanged", rdata, 8'h00);
        tick_n(MIN, "R4 quiet");
        svc(8'h19, 1'b1, "R4 enable mismatch");
        chk("R4 rdata unchanged", rdata, 8'h00);
        tick_n(MIN, "R3 quiet");
        svc(8'h1A, 1'b1, "R3 wrong key later");
        tick_n(lim(0) - 1, "R6 quiet");
        svc(8'h18, 1'b0, "R6 service at last tick");

        // R8: idle freezes count and ignores writes
        tick_n(20, "R8 quiet");
        idle = 1'b1;
        tick_n(100, "R8 idle ticks");
        svc(8'h00, 1'b0, "R8 write in idle ignored");
        idle = 1'b0;
        tick_n(lim(0) - 1 - 20, "R8 resumed count");
        tick_expire("R8 timeout after idle");

        // R9 monitor off: halt and clk_fail harmless, count frozen in halt
        halt = 1'b1;
        tick_n(30, "R9 halt monitor off");
        clk_fail = 1'b1;
        tick_n(30, "R9 clk_fail monitor off");
        halt = 1'b0; clk_fail = 1'b0;
        tick_n(lim(0) - 1, "R8 halt froze count");
        tick_expire("R8 timeout after halt");

        // R10: idle exit restarts window
        tick_n(25, "R10 quiet");
        idle = 1'b1;
        tick_n(5, "R10 idle");
        idle = 1'b0; idle_exit = 1'b1;
        @(negedge clk);
        idle_exit = 1'b0;
        chk("R10 no error on exit", {7'd0, err}, 8'h00);
        tick_n(3, "R10 quiet");
        svc(8'h18, 1'b1, "R10 early after idle exit");
        tick_n(MIN, "R10 quiet");
        svc(8'h18, 1'b0, "R10 service ok");
        tick_n(25, "R10 quiet");
        idle_exit = 1'b1;
        @(negedge clk);
        idle_exit = 1'b0;
        tick_n(lim(0) - 1, "R10 full window after exit");
        tick_expire("R10 timeout after exit");

        // second reset: default window, bad first key, monitor on
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata after re-reset", rdata, 8'hC1);
        tick_n(lim(3) - 1, "R1 R6 default window");
        tick_expire("R6 default timeout");
        svc(8'h5A, 1'b1, "R3 first service bad key");
        chk("R3 nothing loaded", rdata, 8'hC1);
        svc(8'h18, 1'b1, "R4 config already used");
        chk("R4 rdata unchanged", rdata, 8'hC1);
        tick_n(MIN, "R4 quiet");
        svc(8'hD9, 1'b0, "R4 matching default fields");

        clk_fail = 1'b1;
        @(negedge clk);
        chk("R9 clk_fail rise", {7'd0, err}, 8'h01);
        @(negedge clk);
        chk("R9 R7 single pulse", {7'd0, err}, 8'h00);
        tick_n(MIN, "R9 held fault quiet");
        svc(8'hD9, 1'b1, "R9 service during fault");
        clk_fail = 1'b0;
        @(negedge clk);
        halt = 1'b1;
        @(negedge clk);
        chk("R9 halt with monitor", {7'd0, err}, 8'h01);
        @(negedge clk);
        chk("R9 R7 single pulse", {7'd0, err}, 8'h00);
        halt = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule